// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a register of eight stages, modelled inside one system clock domain, that turns a parallel byte into a serial bit stream. While the active-low load input is held low, every stage copies its parallel input. While load is high, each rising edge of an external shift clock moves the contents one stage toward the last stage, and the first stage takes the serial input. Both the last stage and its inverse are driven out. A chain of such registers widens the input: the last-stage output of one drives the serial input of the next.

The external shift clock and its active-low enable are not used as clocks. Each passes through its own synchronizer. The block then looks for a rising edge on the OR of the two synchronized lines, so either line can serve as the clock and the other as the inhibit. A rise of the enable while the clock is low therefore counts as a shift edge, just as a rise of the clock does. Load takes priority over any shift in the same cycle. An active-high synchronous reset clears the register.

Top module: `piso_shift_reg`

## Requirements
- R1: One system cycle after reset is released, all stages are zero, ser_out is 0 and ser_out_n is 1. The synchronizer and edge-detect flops reset to the inhibited (high) level, so a low clock and a low enable after reset do not cause a shift.
- R2: While load_n is low, every stage i takes par_in[i] on each system clock edge, whatever sclk, sclk_en_n and ser_in are doing. ser_out shows par_in[WIDTH-1] one system cycle after par_in is applied.
- R3: par_in may change while load_n stays low. The stages follow each new value, and the value present in the last cycle with load_n low is kept after load_n rises.
- R4: With load_n high and sclk_en_n low, a rising edge of sclk moves stage i to stage i+1 and loads ser_in into stage 0. Stage WIDTH-1 drives ser_out. The shift takes effect SYNC_STAGES+1 system cycles after the edge is applied.
- R5: With load_n high and sclk_en_n held high, rising or falling edges of sclk leave the stages unchanged.
- R6: The shift edge is the rising edge of (sclk OR sclk_en_n). A rise of sclk_en_n while sclk is low causes exactly one shift, and a fall of either line causes none.
- R7: ser_out_n is the inverse of ser_out in every cycle after reset.
- R8: A shift edge that is detected while load_n is low is discarded. After load_n rises, the stages hold the loaded value until a new edge arrives.
- R9: Each rising edge causes exactly one shift, however long the OR stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel capture, active low |
| sclk | input | 1 | External shift clock, rising edge active |
| sclk_en_n | input | 1 | Shift clock enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit i into stage i |
| ser_out | output | 1 | Value of the last stage |
| ser_out_n | output | 1 | Inverse of the last stage |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and SYNC_STAGES of 2. With these values a full byte can be shifted out bit by bit, so every stage can be observed at ser_out. The edge latency of three system cycles is short enough to test edges that land while load is low. The same settings make it possible to enter the inhibit with the clock high, without a shift. They also let a rise of the enable act as a spurious edge, and the bench checks that this shift moves the data by exactly one place.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } piso_act_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q[0] <= din;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_line,
  input  logic en_line,
  output logic fire
);
  logic clk_s;
  logic en_s;
  logic or_s;
  logic or_prev_q;

  piso_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_clk (
    .clk  (clk),
    .rst  (rst),
    .din  (clk_line),
    .dout (clk_s)
  );

  piso_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_en (
    .clk  (clk),
    .rst  (rst),
    .din  (en_line),
    .dout (en_s)
  );

  assign or_s = clk_s | en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      or_prev_q <= 1'b1;
    end else begin
      or_prev_q <= or_s;
    end
  end

  assign fire = or_s & ~or_prev_q;
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic      load_n,
  input  logic      fire,
  output piso_act_e act
);
  always_comb begin
    if (!load_n) begin
      act = ACT_LOAD;
    end else if (fire) begin
      act = ACT_SHIFT;
    end else begin
      act = ACT_HOLD;
    end
  end
endmodule

// File: rtl/piso_stages.sv
module piso_stages
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  piso_act_e        act,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] d_next
);
  logic [WIDTH-1:0] q_r;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_left;
    if (i == 0) begin : g_first
      assign from_left = ser_in;
    end else begin : g_rest
      assign from_left = q_r[i-1];
    end

    always_comb begin
      case (act)
        ACT_LOAD:  d_next[i] = par_in[i];
        ACT_SHIFT: d_next[i] = from_left;
        default:   d_next[i] = q_r[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      q_r <= d_next;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             sclk,
  input  logic             sclk_en_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int LAST = WIDTH - 1;

  logic             shift_fire;
  piso_act_e        act;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic             out_n_q;

  piso_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .clk_line (sclk),
    .en_line  (sclk_en_n),
    .fire     (shift_fire)
  );

  piso_ctrl u_ctrl (
    .load_n (load_n),
    .fire   (shift_fire),
    .act    (act)
  );

  piso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .ser_in (ser_in),
    .par_in (par_in),
    .q      (stage_q),
    .d_next (stage_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_n_q <= 1'b1;
    end else begin
      out_n_q <= ~stage_d[LAST];
    end
  end

  assign ser_out   = stage_q[LAST];
  assign ser_out_n = out_n_q;
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_q,
  input logic             shift_fire,
  input logic             ser_out,
  input logic             ser_out_n
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d === 1'b1 && rst === 1'b0) begin
      p_reset_clear_r1: assert (stage_q == '0 && ser_out_n == 1'b1)
        else $error("stages not cleared after reset");
    end
  end

  p_load_track_r2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> stage_q == $past(par_in));

  p_shift_move_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && shift_fire) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n && !shift_fire) |=> $stable(stage_q));

  p_complement_r7: assert property (@(posedge clk) disable iff (rst)
    ser_out_n == ~ser_out);

  p_single_fire_r9: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> !shift_fire);
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_n     (load_n),
  .ser_in     (ser_in),
  .par_in     (par_in),
  .stage_q    (stage_q),
  .shift_fire (shift_fire),
  .ser_out    (ser_out),
  .ser_out_n  (ser_out_n)
);

// File: tb/piso_shift_reg_tb.sv
`timescale 1ns/1ps
module piso_shift_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_n = 1'b1;
  logic         sclk = 1'b0;
  logic         sclk_en_n = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;
  logic         ser_out_n;

  always #2.5 clk = ~clk;

  piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .load_n    (load_n),
    .sclk      (sclk),
    .sclk_en_n (sclk_en_n),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t        sb_q[$];
  int           n_checks = 0;
  int           n_fails = 0;
  logic [W-1:0] model = '0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (ser_out !== it.exp) begin
        n_fails++;
        $display("FAIL %s ser_out actual=%b expected=%b", it.tag, ser_out, it.exp);
      end
      n_checks++;
      if (ser_out_n !== ~it.exp) begin
        n_fails++;
        $display("FAIL R7 ser_out_n actual=%b expected=%b (%s)", ser_out_n, ~it.exp, it.tag);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag);
    item_t it;
    it.exp = model[W-1];
    it.tag = tag;
    sb_q.push_back(it);
    step(1);
  endtask

  // drive clock and enable lines; model shifts on a rise of their OR
  task automatic set_lines(input logic c, input logic e, input logic s);
    logic old_or;
    old_or    = sclk | sclk_en_n;
    ser_in    = s;
    sclk      = c;
    sclk_en_n = e;
    step(6);
    if (!old_or && (c | e) && load_n) model = {model[W-2:0], s};
  endtask

  task automatic load_byte(input logic [W-1:0] a, input logic [W-1:0] b);
    load_n = 1'b0;
    par_in = a;
    step(2);
    model = a;
    expect_out("R2 load capture");
    par_in = b;
    step(2);
    model = b;
    expect_out("R3 load tracking");
    load_n = 1'b1;
    step(2);
    expect_out("R3 value kept after load");
  endtask

  task automatic shift_out(input string tag, input logic s);
    for (int k = 0; k < W; k++) begin
      set_lines(1'b1, 1'b0, s);
      expect_out(tag);
      set_lines(1'b0, 1'b0, s);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(4);
    model = '0;
    expect_out("R1 reset state");

    // load then shift out, data pattern A (R2, R3, R4, R9)
    load_byte(8'hFF, 8'hA5);
    shift_out("R4 shift byte A5", 1'b0);
    expect_out("R4 zeros fed in");

    // second pattern, ones fed in
    load_byte(8'h00, 8'h3C);
    shift_out("R4 shift byte 3C ones in", 1'b1);

    // R9: hold clock high for long; only one shift
    load_byte(8'h12, 8'h81);
    set_lines(1'b1, 1'b0, 1'b0);
    step(20);
    expect_out("R9 single shift on long high");
    set_lines(1'b0, 1'b0, 1'b0);

    // R5: enter inhibit with clock high, then toggle clock
    load_byte(8'h00, 8'hC9);
    set_lines(1'b1, 1'b0, 1'b1);
    expect_out("R4 shift before inhibit");
    set_lines(1'b1, 1'b1, 1'b1);
    set_lines(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) begin
      set_lines(1'b1, 1'b1, 1'b0);
      expect_out("R5 inhibited clock high");
      set_lines(1'b0, 1'b1, 1'b0);
      expect_out("R5 inhibited clock low");
    end
    set_lines(1'b0, 1'b0, 1'b0);
    expect_out("R6 enable fall no shift");
    shift_out("R5 contents held", 1'b0);

    // R6: enable rising while clock low causes a shift
    load_byte(8'h00, 8'h6E);
    set_lines(1'b0, 1'b1, 1'b1);
    expect_out("R6 spurious enable edge");
    set_lines(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < W - 1; k++) begin
      set_lines(1'b0, 1'b1, 1'b0);
      expect_out("R6 enable used as clock");
      set_lines(1'b0, 1'b0, 1'b0);
    end

    // R8: edge during load is discarded
    load_n = 1'b0;
    par_in = 8'hB4;
    set_lines(1'b1, 1'b0, 1'b1);
    set_lines(1'b0, 1'b0, 1'b1);
    model = 8'hB4;
    load_n = 1'b1;
    step(2);
    expect_out("R8 no shift after load release");
    shift_out("R8 loaded byte intact", 1'b0);

    // R2: clock and serial activity during load are ignored
    load_n = 1'b0;
    par_in = 8'h5A;
    for (int k = 0; k < 3; k++) begin
      set_lines(1'b1, 1'b0, 1'b1);
      set_lines(1'b0, 1'b0, 1'b0);
    end
    model = 8'h5A;
    expect_out("R2 load ignores clock");
    load_n = 1'b1;
    step(2);
    shift_out("R2 loaded byte out", 1'b0);

    // R1: reset in the middle clears everything
    load_byte(8'hFF, 8'hFF);
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    model = '0;
    expect_out("R1 reset clears stages");
    shift_out("R1 all stages zero", 1'b0);

    step(4);
    finish_run();
  end
endmodule